// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a clocked model of the command front end of a byte-wide flash memory that has uniform sectors. It watches the asynchronous chip-enable, write-enable and output-enable strobes, the address bus and the data bus. It finds write cycles, decodes the unlock-prefixed command sequences and tracks the current mode: array read, identification (autoselect), program busy, erase busy or error. The storage array itself is not modelled. The embedded program and erase algorithms are stood in for by a launch pulse (`op_start` with address, data and kind), a completion input (`op_done`), a failure input (`op_fail`) and an internal busy timeout.

While the block is in identification mode, reads return a manufacturer byte, a device byte or a protection byte for the addressed sector. Protection comes from the `sect_prot` input, and the top address bits select the sector. The strobes pass through two-flop synchronisers. The address is latched when the write condition first becomes true. The data is taken, and the write committed, when the condition ends through chip-enable or write-enable rising while output-enable is still high.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, `mode` is 0 (array read), `err` is 0, `id_valid` is 0 and `op_start` is 0.
- R2: A write counts only while `ce_n`=0, `we_n`=0 and `oe_n`=1. If `oe_n` is low when the strobes are active, the cycle has no effect on the sequence.
- R3: The address of a write is the one present when `ce_n` and `we_n` first become jointly low. Later address changes within the same cycle are ignored.
- R4: Writing AAh to 555h, then 55h to 2AAh, then 90h to 555h enters identification mode (`mode`=1). Only address bits [10:0] are compared.
- R5: A read in identification mode asserts `id_valid`. With A6=0 and A1=0 it returns 01h when A0=0 and 20h when A0=1. With A1=1 and A0=0 it returns 01h for a protected sector and 00h otherwise, where the sector index is addr[16:14]. All other reads return 00h.
- R6: Identification mode survives reads and writes other than F0h. A write of F0h, at any address, returns to `mode`=0.
- R7: The unlock pair followed by A0h to 555h arms programming. The next write pulses `op_start` with `op_erase`=0, that write's address and data, and `mode` becomes 2 until `op_done`.
- R8: The unlock pair, 80h to 555h, the unlock pair again, then 30h to any address starts a sector erase (`op_chip`=0, `op_addr`= that address). A final 10h to 555h instead starts a chip erase (`op_chip`=1). In both cases `mode` is 3 until `op_done`.
- R9: F0h written at any point inside a sequence aborts it. Following command bytes then do not complete the sequence.
- R10: While `mode` is 2 or 3, all writes, including F0h, are ignored.
- R11: A wrong address or data at any step of a sequence returns to array read. A later valid command byte then has no effect.
- R12: `op_fail` while busy, or `TIMEOUT_CYC` busy cycles without `op_done`, enters the error state (`mode`=4, `err`=1). Only an F0h write leaves it, to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W (17) | Byte address |
| din | input | 8 | Write data |
| sect_prot | input | NSECT (8) | Protection status per sector |
| op_done | input | 1 | Embedded operation finished |
| op_fail | input | 1 | Embedded operation failed |
| mode | output | 3 | 0 read, 1 identification, 2 programming, 3 erasing, 4 error |
| err | output | 1 | Error flag (status bit 5) |
| op_start | output | 1 | One-cycle launch of an embedded operation |
| op_erase | output | 1 | Launched operation is an erase |
| op_chip | output | 1 | Launched erase covers the whole chip |
| op_addr | output | ADDR_W (17) | Address of the launched operation |
| op_data | output | 8 | Data byte of a launched program |
| id_valid | output | 1 | Identification read data valid |
| id_data | output | 8 | Identification read data |

## Verification
The hardest case to reach from the pins is a reset command that lands inside the protected window of an embedded operation. The bench builds a full program sequence, holds `op_done` low, writes F0h while `mode` reads 2, and only then releases completion. The busy timeout is reached by starting a program and not answering it for more than `TIMEOUT_CYC` cycles. Address capture is tested by changing the address bus in the middle of a write cycle, after the strobes have been seen low.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_AUTO  = 3'd1,
    MODE_PROG  = 3'd2,
    MODE_ERASE = 3'd3,
    MODE_ERROR = 3'd4
  } mode_e;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PSET, ST_E0, ST_E1, ST_E2,
    ST_AUTO, ST_BUSY_P, ST_BUSY_E, ST_ERROR
  } seq_e;

  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_AUTO  = 8'h90;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERS   = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [15:0] ADR_KEY1 = 16'h0555;
  localparam logic [15:0] ADR_KEY2 = 16'h02AA;
  localparam logic [7:0] ID_MFR    = 8'h01;
  localparam logic [7:0] ID_DEV    = 8'h20;
endpackage

// File: rtl/fcs_wr_detect.sv
module fcs_wr_detect #(
  parameter int ADDR_W = 17,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act
);
  // strobe synchronisers: index 0 = ce, 1 = we, 2 = oe
  logic [SYNC_N-1:0] sync_q [3];
  logic [2:0] raw;
  assign raw = {oe_n, we_n, ce_n};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= '1;
      else        sync_q[g] <= {sync_q[g][SYNC_N-2:0], raw[g]};
    end
  end

  logic ce_s, we_s, oe_s, wr_cond, wr_cond_q;
  logic [ADDR_W-1:0] adr_lat;
  assign ce_s    = sync_q[0][SYNC_N-1];
  assign we_s    = sync_q[1][SYNC_N-1];
  assign oe_s    = sync_q[2][SYNC_N-1];
  assign wr_cond = !ce_s && !we_s && oe_s;
  assign rd_act  = !ce_s && !oe_s && we_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cond_q <= 1'b0;
      adr_lat   <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_cond_q <= wr_cond;
      wr_stb    <= 1'b0;
      if (wr_cond && !wr_cond_q) adr_lat <= addr;
      if (wr_cond_q && !wr_cond && oe_s) begin
        wr_stb  <= 1'b1;
        wr_addr <= adr_lat;
        wr_data <= din;
      end
    end
  end

  AST_WR_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R2
  AST_WR_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(oe_s)); // R2
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int CMP_W       = 11,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  input  logic              op_fail,
  output seq_e              state,
  output logic              op_start,
  output logic              op_erase,
  output logic              op_chip,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic at_k1, at_k2, is_u1, is_u2, busy;
  logic go, go_erase, go_chip;
  seq_e nxt;

  assign at_k1 = wr_addr[CMP_W-1:0] == ADR_KEY1[CMP_W-1:0];
  assign at_k2 = wr_addr[CMP_W-1:0] == ADR_KEY2[CMP_W-1:0];
  assign is_u1 = at_k1 && wr_data == CMD_KEY1;
  assign is_u2 = at_k2 && wr_data == CMD_KEY2;
  assign busy  = state == ST_BUSY_P || state == ST_BUSY_E;

  always_comb begin
    nxt      = state;
    go       = 1'b0;
    go_erase = 1'b0;
    go_chip  = 1'b0;
    case (state)
      ST_READ: if (is_u1) nxt = ST_U1;
      ST_U1:   nxt = is_u2 ? ST_U2 : ST_READ;
      ST_U2: begin
        if (at_k1 && wr_data == CMD_AUTO)      nxt = ST_AUTO;
        else if (at_k1 && wr_data == CMD_PROG) nxt = ST_PSET;
        else if (at_k1 && wr_data == CMD_ERS)  nxt = ST_E0;
        else                                   nxt = ST_READ;
      end
      ST_PSET: begin
        if (wr_data == CMD_RESET) nxt = ST_READ;
        else begin
          nxt = ST_BUSY_P;
          go  = 1'b1;
        end
      end
      ST_E0: nxt = is_u1 ? ST_E1 : ST_READ;
      ST_E1: nxt = is_u2 ? ST_E2 : ST_READ;
      ST_E2: begin
        if (wr_data == CMD_SECT) begin
          nxt = ST_BUSY_E; go = 1'b1; go_erase = 1'b1;
        end else if (at_k1 && wr_data == CMD_CHIP) begin
          nxt = ST_BUSY_E; go = 1'b1; go_erase = 1'b1; go_chip = 1'b1;
        end else nxt = ST_READ;
      end
      ST_AUTO, ST_ERROR: if (wr_data == CMD_RESET) nxt = ST_READ;
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      cnt      <= '0;
      op_start <= 1'b0;
      op_erase <= 1'b0;
      op_chip  <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= 1'b0;
      if (busy) begin
        if (op_fail || cnt == TMO_LAST) state <= ST_ERROR;
        else if (op_done)               state <= ST_READ;
        else                            cnt   <= cnt + 1'b1;
      end else if (wr_stb) begin
        state <= nxt;
        if (go) begin
          op_start <= 1'b1;
          op_erase <= go_erase;
          op_chip  <= go_chip;
          op_addr  <= wr_addr;
          op_data  <= wr_data;
          cnt      <= '0;
        end
      end
    end
  end

  AST_BUSY_IGNORES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done && !op_fail && cnt != TMO_LAST) |=> busy); // R10
  AST_ERROR_EXIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERROR) |=> (state == ST_ERROR || state == ST_READ)); // R12
  AST_START_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> ($past(state) == ST_PSET || $past(state) == ST_E2)); // R7
  AST_AUTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AUTO && !(wr_stb && wr_data == CMD_RESET)) |=> state == ST_AUTO); // R6
endmodule

// File: rtl/fcs_id_read.sv
module fcs_id_read
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int NSECT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_auto,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSECT-1:0]  sect_prot,
  output logic              id_valid,
  output logic [7:0]        id_data
);
  localparam int SEC_W = $clog2(NSECT);
  logic [SEC_W-1:0] sec;
  logic [7:0] dec;
  assign sec = addr[ADDR_W-1 -: SEC_W];

  always_comb begin
    dec = 8'h00;
    if (!addr[6] && !addr[1]) dec = addr[0] ? ID_DEV : ID_MFR;
    else if (addr[1] && !addr[0]) dec = {7'd0, sect_prot[sec]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_data  <= '0;
    end else begin
      id_valid <= in_auto && rd_act;
      id_data  <= (in_auto && rd_act) ? dec : 8'h00;
    end
  end

  AST_ID_ONLY_IN_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(in_auto)); // R5
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int NSECT       = 8,
  parameter int CMP_W       = 11,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              op_done,
  input  logic              op_fail,
  output logic [2:0]        mode,
  output logic              err,
  output logic              op_start,
  output logic              op_erase,
  output logic              op_chip,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              id_valid,
  output logic [7:0]        id_data
);
  logic              wr_stb, rd_act;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  seq_e              state;
  mode_e             mode_v;

  fcs_wr_detect #(.ADDR_W(ADDR_W), .SYNC_N(2)) u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act)
  );

  fcs_seq #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .op_fail(op_fail), .state(state),
    .op_start(op_start), .op_erase(op_erase), .op_chip(op_chip),
    .op_addr(op_addr), .op_data(op_data)
  );

  fcs_id_read #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_id (
    .clk(clk), .rst_n(rst_n), .in_auto(state == ST_AUTO), .rd_act(rd_act),
    .addr(addr), .sect_prot(sect_prot), .id_valid(id_valid), .id_data(id_data)
  );

  always_comb begin
    case (state)
      ST_AUTO:              mode_v = MODE_AUTO;
      ST_BUSY_P:            mode_v = MODE_PROG;
      ST_BUSY_E:            mode_v = MODE_ERASE;
      ST_ERROR:             mode_v = MODE_ERROR;
      default:              mode_v = MODE_READ;
    endcase
  end
  assign mode = mode_v;
  assign err  = state == ST_ERROR;

  AST_LAUNCH_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (mode == MODE_PROG || mode == MODE_ERASE)); // R8
endmodule

// File: tb/flash_cmd_fsm_tb.sv
module flash_cmd_fsm_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  sect_prot = 8'b0000_0100;
  logic op_done = 1'b0, op_fail = 1'b0;
  logic [2:0] mode;
  logic err, op_start, op_erase, op_chip, id_valid;
  logic [16:0] op_addr;
  logic [7:0] op_data, id_data;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;
  bit seen_start = 1'b0, cap_erase, cap_chip;
  logic [16:0] cap_addr;
  logic [7:0] cap_data;

  always #5 clk = ~clk;

  flash_cmd_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .sect_prot(sect_prot), .op_done(op_done),
    .op_fail(op_fail), .mode(mode), .err(err), .op_start(op_start),
    .op_erase(op_erase), .op_chip(op_chip), .op_addr(op_addr),
    .op_data(op_data), .id_valid(id_valid), .id_data(id_data)
  );

  always @(posedge clk) if (op_start) begin
    seen_start <= 1'b1;
    cap_erase  <= op_erase;
    cap_chip   <= op_chip;
    cap_addr   <= op_addr;
    cap_data   <= op_data;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [16:0] a, input logic [7:0] d,
                           input logic oe_low = 1'b0, input logic [16:0] a_late = 17'h1FFFF);
    @(negedge clk);
    addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (4) @(negedge clk);
    if (a_late != 17'h1FFFF) addr = a_late;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
    oe_n = 1'b1;
  endtask

  task automatic bus_read(input logic [16:0] a, output logic v, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    v = id_valid; d = id_data;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock();
    bus_write(17'h00555, 8'hAA);
    bus_write(17'h002AA, 8'h55);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 err", err, 0);
    chk("R1 id_valid", id_valid, 0);
    chk("R1 op_start", op_start, 0);
  endtask

  task automatic t_autoselect();
    logic v; logic [7:0] d;
    unlock(); bus_write(17'h00555, 8'h90);
    chk("R4 enter id mode", mode, 1);
    bus_read(17'h00000, v, d); chk("R5 valid", v, 1); chk("R5 mfr", d, 8'h01);
    bus_read(17'h00001, v, d); chk("R5 dev", d, 8'h20);
    bus_read(17'h08002, v, d); chk("R5 prot sector2", d, 8'h01);
    bus_read(17'h0C002, v, d); chk("R5 unprot sector3", d, 8'h00);
    bus_read(17'h00040, v, d); chk("R5 A6 high", d, 8'h00);
    bus_write(17'h00555, 8'hAA);
    chk("R6 non-reset write keeps id mode", mode, 1);
    bus_write(17'h12345, 8'hF0);
    chk("R6 reset exits", mode, 0);
    bus_read(17'h00000, v, d); chk("R6 no id after exit", v, 0);
  endtask

  task automatic t_qualify();
    bus_write(17'h00555, 8'hAA, 1'b1);
    bus_write(17'h002AA, 8'h55);
    bus_write(17'h00555, 8'h90);
    chk("R2 oe low inhibits write", mode, 0);
  endtask

  task automatic t_addr_capture();
    bus_write(17'h00555, 8'hAA, 1'b0, 17'h00123);
    bus_write(17'h002AA, 8'h55, 1'b0, 17'h00777);
    bus_write(17'h00555, 8'h90);
    chk("R3 first address used", mode, 1);
    bus_write(17'h00000, 8'hF0);
  endtask

  task automatic t_program();
    seen_start = 1'b0;
    unlock(); bus_write(17'h00555, 8'hA0);
    chk("R7 no start before data", seen_start, 0);
    bus_write(17'h01234, 8'h5A);
    chk("R7 start seen", seen_start, 1);
    chk("R7 kind", cap_erase, 0);
    chk("R7 addr", cap_addr, 17'h01234);
    chk("R7 data", cap_data, 8'h5A);
    chk("R7 mode busy", mode, 2);
    bus_write(17'h00000, 8'hF0);
    chk("R10 reset ignored while busy", mode, 2);
    pulse(op_done);
    chk("R7 done returns to read", mode, 0);
  endtask

  task automatic t_erase();
    seen_start = 1'b0;
    unlock(); bus_write(17'h00555, 8'h80); unlock();
    bus_write(17'h0C000, 8'h30);
    chk("R8 sector start", seen_start, 1);
    chk("R8 sector erase kind", cap_erase, 1);
    chk("R8 sector not chip", cap_chip, 0);
    chk("R8 sector addr", cap_addr, 17'h0C000);
    chk("R8 mode erase", mode, 3);
    pulse(op_done);
    seen_start = 1'b0;
    unlock(); bus_write(17'h00555, 8'h80); unlock();
    bus_write(17'h00555, 8'h10);
    chk("R8 chip erase flag", cap_chip, 1);
    chk("R8 chip mode", mode, 3);
    pulse(op_done);
    chk("R8 back to read", mode, 0);
  endtask

  task automatic t_abort();
    seen_start = 1'b0;
    unlock(); bus_write(17'h00000, 8'hF0);
    bus_write(17'h00555, 8'hA0); bus_write(17'h01000, 8'h11);
    chk("R9 abort after unlock", seen_start, 0);
    unlock(); bus_write(17'h00555, 8'h80); bus_write(17'h00000, 8'hF0);
    unlock(); bus_write(17'h00000, 8'h30);
    chk("R9 abort inside erase setup", seen_start, 0);
    chk("R9 mode read", mode, 0);
  endtask

  task automatic t_bad_seq();
    bus_write(17'h00555, 8'hAA); bus_write(17'h002AB, 8'h55);
    bus_write(17'h00555, 8'h90);
    chk("R11 wrong address drops", mode, 0);
    bus_write(17'h00555, 8'hAA); bus_write(17'h002AA, 8'h56);
    bus_write(17'h00555, 8'h90);
    chk("R11 wrong data drops", mode, 0);
  endtask

  task automatic t_error();
    unlock(); bus_write(17'h00555, 8'hA0); bus_write(17'h00010, 8'h01);
    pulse(op_fail);
    chk("R12 fail to error", mode, 4);
    chk("R12 err flag", err, 1);
    bus_write(17'h00555, 8'hAA);
    chk("R12 other write ignored", mode, 4);
    bus_write(17'h00000, 8'hF0);
    chk("R12 reset exits error", mode, 0);
    unlock(); bus_write(17'h00555, 8'hA0); bus_write(17'h00020, 8'h02);
    repeat (300) @(negedge clk);
    chk("R12 timeout to error", err, 1);
    bus_write(17'h00000, 8'hF0);
    chk("R12 clear after timeout", err, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_autoselect();
    t_qualify();
    t_addr_capture();
    t_program();
    t_erase();
    t_abort();
    t_bad_seq();
    t_error();
    finish_run();
  end
endmodule